// File: doc/BRIEF.md
# ROM Window Address Decoder

This block holds the configuration word for one ROM/Flash bank and decides, for every processor bus access, whether that bank is selected. The 32-bit configuration word gives a 12-bit window base, a 3-bit size code, an enable bit, a write-permit bit, a boot alias bit and a read-only strap bit that reports a 64-bit bank width. Software writes and reads the word through a simple single-cycle register port.

The decode is purely combinational. The bus address is compared against the programmed window, whose base is forced onto a multiple of the window size, and against the top 1 MB of the address space when the boot alias is on. The outputs are a bank select, a write strobe or a blocked-write flag, and the byte offset within the bank. Software must keep the bank idle for a short period before and after any write to the configuration word. The block does not detect a window that overlaps another slave.

Top module: `romWindowDecoder`

## Requirements
- R1: After reset the configuration word reads 0xFF400000, with bit 13 equal to the strap input. Base is 0xFF4, and size, enable, write-permit and alias are all 0.
- R2: A register write loads base from bits 31:20, the size code from bits 19:17, enable from bit 16, write-permit from bit 15 and alias from bit 14. All five fields read back unchanged one cycle later.
- R3: Bit 13 always reads the strap input and bits 12:0 always read zero, whatever value is written.
- R4: With size code n (0 to 7), the window covers 1 MB << n. It starts at the base value with its low n bits cleared, placed in address bits 31:20. An access hits only inside that range.
- R5: When the enable bit is 0, no access selects the bank, through either the window or the alias.
- R6: When the alias bit and the enable bit are both 1, addresses 0xFFF00000 to 0xFFFFFFFF select the bank as well as the programmed window.
- R7: A write access that selects the bank raises the write strobe when write-permit is 1 and the blocked-write flag when it is 0. The two never assert together, and neither asserts for a read.
- R8: On a window hit the offset is the address masked to the window size. On an alias-only hit it is the address masked to 1 MB. With no hit it is 0.
- R9: When bus valid is low, the bank select, both write flags and the offset are all 0.
- R10: When an address lies in both the window and the alias range, the window offset is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapWide64 | input | 1 | Strap that reports a 64-bit bank width |
| regWrEn | input | 1 | Configuration write strobe |
| regWrData | input | 32 | Configuration write data |
| regRdData | output | 32 | Configuration readback |
| busValid | input | 1 | Bus access valid |
| busAddr | input | 32 | Bus byte address |
| busWrite | input | 1 | Access is a write |
| bankSel | output | 1 | Bank selected |
| writeStrobe | output | 1 | Permitted write to the bank |
| writeBlocked | output | 1 | Write to the bank refused |
| bankOffset | output | 27 | Byte offset within the bank |

## Verification
The checker holds the following on every cycle: the reset value, the read-only and zero bits, the enable and valid gating, write-strobe exclusivity, the zero offset on a miss, and that the alias range always selects when it is switched on. Window placement can only be shown by the bench's scenarios. These walk all eight size codes with an unaligned base, probe the first and last byte of each window and the byte on either side of it, and check the offsets reported where the window and the alias overlap.

// File: rtl/rom_win_pkg.sv
package rom_win_pkg;
  localparam int ADDR_W = 32;
  localparam int BASE_W = 12;
  localparam int SIZE_W = 3;
  localparam int MIN_LOG2 = ADDR_W - BASE_W;            // 1 MB granule
  localparam int MAX_SHIFT = (1 << SIZE_W) - 1;
  localparam int OFFS_W = MIN_LOG2 + MAX_SHIFT;         // 128 MB window

  // configuration word field positions
  localparam int BASE_LSB = 20;
  localparam int SIZE_LSB = 17;
  localparam int EN_BIT = 16;
  localparam int WE_BIT = 15;
  localparam int ALIAS_BIT = 14;
  localparam int STRAP_BIT = 13;

  localparam logic [BASE_W-1:0] RESET_BASE = 12'hFF4;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [SIZE_W-1:0] sizeCode;
    logic enable;
    logic writeEn;
    logic aliasEn;
  } winCfg_t;
endpackage

// File: rtl/romWinCtrl.sv
module romWinCtrl
  import rom_win_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapWide64,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  output winCfg_t           cfg
);
  winCfg_t cfgQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ.base     <= RESET_BASE;
      cfgQ.sizeCode <= '0;
      cfgQ.enable   <= 1'b0;
      cfgQ.writeEn  <= 1'b0;
      cfgQ.aliasEn  <= 1'b0;
    end else if (regWrEn) begin
      cfgQ.base     <= regWrData[BASE_LSB +: BASE_W];
      cfgQ.sizeCode <= regWrData[SIZE_LSB +: SIZE_W];
      cfgQ.enable   <= regWrData[EN_BIT];
      cfgQ.writeEn  <= regWrData[WE_BIT];
      cfgQ.aliasEn  <= regWrData[ALIAS_BIT];
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[BASE_LSB +: BASE_W] = cfgQ.base;
    regRdData[SIZE_LSB +: SIZE_W] = cfgQ.sizeCode;
    regRdData[EN_BIT]    = cfgQ.enable;
    regRdData[WE_BIT]    = cfgQ.writeEn;
    regRdData[ALIAS_BIT] = cfgQ.aliasEn;
    regRdData[STRAP_BIT] = strapWide64;
  end

  assign cfg = cfgQ;
endmodule

// File: rtl/romWinDecode.sv
module romWinDecode
  import rom_win_pkg::*;
(
  input  winCfg_t           cfg,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output logic              bankSel,
  output logic              writeStrobe,
  output logic              writeBlocked,
  output logic [OFFS_W-1:0] bankOffset
);
  logic [BASE_W-1:0] addrHi;
  logic [BASE_W-1:0] cmpMask;
  logic [OFFS_W-1:0] addrLo;
  logic [OFFS_W-1:0] winOffMask;
  logic [OFFS_W-1:0] aliasOffMask;
  logic live;
  logic winHit;
  logic aliasHit;

  assign addrHi = busAddr[ADDR_W-1 -: BASE_W];
  assign addrLo = busAddr[OFFS_W-1:0];
  assign live   = busValid & cfg.enable;

  // one mask bit cleared per size step keeps the base size-aligned
  assign cmpMask = {BASE_W{1'b1}} << cfg.sizeCode;
  assign winOffMask = {OFFS_W{1'b1}} >> (SIZE_W'(MAX_SHIFT) - cfg.sizeCode);
  assign aliasOffMask = {{(OFFS_W-MIN_LOG2){1'b0}}, {MIN_LOG2{1'b1}}};

  assign winHit   = live & (((addrHi ^ cfg.base) & cmpMask) == '0);
  assign aliasHit = live & cfg.aliasEn & (&addrHi);

  always_comb begin
    bankSel      = winHit | aliasHit;
    writeStrobe  = bankSel & busWrite & cfg.writeEn;
    writeBlocked = bankSel & busWrite & ~cfg.writeEn;
    if (winHit)
      bankOffset = addrLo & winOffMask;
    else if (aliasHit)
      bankOffset = addrLo & aliasOffMask;
    else
      bankOffset = '0;
  end
endmodule

// File: rtl/romWindowDecoder.sv
module romWindowDecoder
  import rom_win_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapWide64,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  output logic              bankSel,
  output logic              writeStrobe,
  output logic              writeBlocked,
  output logic [OFFS_W-1:0] bankOffset
);
  winCfg_t cfg;

  romWinCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .strapWide64(strapWide64),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .cfg(cfg)
  );

  romWinDecode u_dec (
    .cfg(cfg), .busValid(busValid), .busAddr(busAddr), .busWrite(busWrite),
    .bankSel(bankSel), .writeStrobe(writeStrobe), .writeBlocked(writeBlocked),
    .bankOffset(bankOffset)
  );
endmodule

// File: rtl/romWinChecker.sv
module romWinChecker
  import rom_win_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              strapWide64,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regWrData,
  input logic [ADDR_W-1:0] regRdData,
  input logic              busValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrite,
  input logic              bankSel,
  input logic              writeStrobe,
  input logic              writeBlocked,
  input logic [OFFS_W-1:0] bankOffset
);
  // R1: a reset cycle leaves the documented reset word
  p_reset_word_r1: assert property (@(posedge clk)
    !rstN |=> regRdData[ADDR_W-1:STRAP_BIT+1] == {RESET_BASE, 6'b0});

  // R3: read-only strap and zero bits
  p_ro_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[STRAP_BIT] == strapWide64 && regRdData[STRAP_BIT-1:0] == '0);

  // R5: disabled bank never selects
  p_enable_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    !regRdData[EN_BIT] |-> !bankSel);

  // R6: alias range always selects when switched on
  p_alias_hit_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && regRdData[EN_BIT] && regRdData[ALIAS_BIT] && (&busAddr[31:20]))
      |-> bankSel);

  // R7: strobe and blocked flag exclusive and only on selected writes
  p_write_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    (writeStrobe || writeBlocked) |->
      (!(writeStrobe && writeBlocked) && bankSel && busWrite
       && (writeStrobe == regRdData[WE_BIT])));

  // R8: no select, no offset
  p_miss_offset_r8: assert property (@(posedge clk) disable iff (!rstN)
    !bankSel |-> bankOffset == '0);

  // R9: idle bus drives nothing
  p_idle_bus_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busValid |-> !bankSel && !writeStrobe && !writeBlocked);

  logic unusedOk;
  assign unusedOk = ^{regWrEn, regWrData};
endmodule

bind romWindowDecoder romWinChecker u_chk (.*);

// File: tb/sim_romWindowDecoder.sv
module sim_romWindowDecoder;
  import rom_win_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapWide64 = 1'b0;
  logic regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic busWrite = 1'b0;
  logic bankSel, writeStrobe, writeBlocked;
  logic [26:0] bankOffset;

  always #5 clk = ~clk;

  romWindowDecoder u0 (.*);

  typedef struct {
    logic sel; logic strobe; logic blocked; logic [26:0] off; string req;
  } expItem_t;
  expItem_t scoreQ[$];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of the configuration
  logic [11:0] mBase = 12'hFF4;
  logic [2:0]  mSize = 0;
  logic mEn = 0, mWe = 0, mAlias = 0;

  function automatic expItem_t predict(logic v, logic [31:0] a, logic w, string req);
    expItem_t e;
    logic [32:0] start, span;
    logic inWin, inAlias;
    start   = {1'b0, mBase & (12'hFFF << mSize), 20'h0};
    span    = 33'd1 << (20 + mSize);
    inWin   = ({1'b0, a} >= start) && ({1'b0, a} < start + span);
    inAlias = mAlias && (a >= 32'hFFF00000);
    e.req = req;
    e.sel = v && mEn && (inWin || inAlias);
    e.strobe = e.sel && w && mWe;
    e.blocked = e.sel && w && !mWe;
    if (!e.sel) e.off = '0;
    else if (inWin) e.off = 27'({1'b0, a} - start);
    else e.off = 27'(a - 32'hFFF00000);
    return e;
  endfunction

  task automatic busCheck(logic [31:0] a, logic w, string req, logic v = 1'b1);
    @(posedge clk); #1;
    busValid = v; busAddr = a; busWrite = w;
    scoreQ.push_back(predict(v, a, w, req));
  endtask

  always @(negedge clk) begin
    while (scoreQ.size() > 0) begin
      expItem_t e;
      e = scoreQ.pop_front();
      checks++;
      if (bankSel !== e.sel || writeStrobe !== e.strobe ||
          writeBlocked !== e.blocked || bankOffset !== e.off) begin
        errors++;
        $display("FAIL %s addr=%h act sel=%b stb=%b blk=%b off=%h exp sel=%b stb=%b blk=%b off=%h",
                 e.req, busAddr, bankSel, writeStrobe, writeBlocked, bankOffset,
                 e.sel, e.strobe, e.blocked, e.off);
      end
    end
  end

  task automatic writeCfg(logic [31:0] d);
    @(posedge clk); #1;
    regWrEn = 1'b1; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    mBase = d[31:20]; mSize = d[19:17]; mEn = d[16]; mWe = d[15]; mAlias = d[14];
  endtask

  function automatic logic [31:0] cfgWord(logic [11:0] b, logic [2:0] s,
                                          logic en, logic we, logic al);
    return {b, s, en, we, al, 14'h0};
  endfunction

  task automatic readCheck(logic [31:0] exp, string req);
    @(negedge clk);
    checks++;
    if (regRdData !== exp) begin
      errors++;
      $display("FAIL %s readback act=%h exp=%h", req, regRdData, exp);
    end
  endtask

  initial begin
    logic [32:0] st, sp;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset word
    readCheck(32'hFF400000, "R1");
    busCheck(32'hFF400000, 1'b0, "R1_R5 disabled after reset");
    // R2 field readback
    writeCfg(cfgWord(12'h5A7, 3'd5, 1'b1, 1'b0, 1'b1));
    readCheck(32'h5A7B4000, "R2");
    // R3 read-only bits ignore writes
    writeCfg(32'hFFFFFFFF);
    readCheck(32'hFFFFC000, "R3");
    strapWide64 = 1'b1;
    readCheck(32'hFFFFE000, "R3 strap");
    writeCfg(32'h00001FFF);
    readCheck(32'h00002000, "R3 zero write");
    strapWide64 = 1'b0;
    // R4 / R8 every size code with an unaligned base
    for (int s = 0; s < 8; s++) begin
      writeCfg(cfgWord(12'h5A7, 3'(s), 1'b1, 1'b1, 1'b0));
      st = {1'b0, 12'h5A7 & (12'hFFF << s), 20'h0};
      sp = 33'd1 << (20 + s);
      busCheck(st[31:0], 1'b0, "R4 first byte");
      busCheck(32'(st + sp - 1), 1'b0, "R4_R8 last byte");
      busCheck(32'(st + sp), 1'b0, "R4 above");
      busCheck(32'(st - 1), 1'b0, "R4 below");
      busCheck(32'h5A712345, 1'b1, "R8 base addr");
    end
    // R6 alias
    writeCfg(cfgWord(12'h100, 3'd0, 1'b1, 1'b1, 1'b1));
    busCheck(32'hFFF12345, 1'b0, "R6 alias hit");
    busCheck(32'hFFEFFFFF, 1'b0, "R6 below alias");
    busCheck(32'h10054321, 1'b0, "R6 window still");
    writeCfg(cfgWord(12'h100, 3'd0, 1'b1, 1'b1, 1'b0));
    busCheck(32'hFFF12345, 1'b0, "R6 alias off");
    // R5 enable gating
    writeCfg(cfgWord(12'h100, 3'd0, 1'b0, 1'b1, 1'b1));
    busCheck(32'hFFF12345, 1'b0, "R5 alias disabled");
    busCheck(32'h10000010, 1'b1, "R5 window disabled");
    // R10 window precedence over alias
    writeCfg(cfgWord(12'hFF0, 3'd4, 1'b1, 1'b1, 1'b1));
    busCheck(32'hFFF23456, 1'b0, "R10 overlap");
    // R7 write permit
    writeCfg(cfgWord(12'h200, 3'd1, 1'b1, 1'b0, 1'b0));
    busCheck(32'h20100000, 1'b1, "R7 blocked");
    busCheck(32'h20100000, 1'b0, "R7 read");
    writeCfg(cfgWord(12'h200, 3'd1, 1'b1, 1'b1, 1'b0));
    busCheck(32'h20100000, 1'b1, "R7 strobe");
    // R9 bus idle
    busCheck(32'h20100000, 1'b1, "R9 idle", 1'b0);
    @(posedge clk); #1 busValid = 1'b0;
    repeat (2) @(posedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule